// File: doc/BRIEF.md
# Configuration Cycle Router

This block sits on the upstream port of a bus bridge and sorts each configuration address phase it is shown. It works on one address phase at a time. For each phase it picks one action. The bridge may take the cycle for its own register file. It may re-issue the cycle downstream as a local (Type 0) access, pass it downstream untouched as a hierarchical (Type 1) access, or turn it into a broadcast special cycle. Otherwise the cycle is left unclaimed. The same block also handles the reverse direction. For phases seen on the downstream side, only the special-cycle request is honoured.

When a hierarchical access is aimed at the bus directly below the bridge, the block rebuilds the address as a local access. The slot number is turned into a single asserted select line in the upper address half. A per-slot hide mask can steer chosen slots onto one shared high select line instead. The host then never finds those devices during normal scanning.

The result is registered and appears one clock after the address phase is presented. The block also keeps the slot number the bridge was last written at, and shows it on a port.

Top module: `cfg_route`

## Requirements
- R1: After reset, `act_valid` is 0, `act` is 0 (none), `xlat_addr` is 0 and `own_dev` is 0.
- R2: An upstream-side phase is claimed for the bridge (action code 1) when `cmd` is configuration read (4'b1010) or write (4'b1011), `addr[1:0]` is 2'b00 and `idsel` is 1. In that case `xlat_addr` equals `addr`.
- R3: A phase whose command is not a configuration command yields action 0 with `xlat_addr` 0. So does a phase with `addr[1:0]` of 2'b10 or 2'b11, and an upstream local-format phase without `idsel`.
- R4: An upstream hierarchical phase (`addr[1:0]`=2'b01) whose bus field `addr[23:16]` equals `sec_bus` yields action 2 (convert to local). In that case `xlat_addr[15:11]` is 0, `xlat_addr[10:2]` is `addr[10:2]` and `xlat_addr[1:0]` is 2'b00.
- R5: On conversion, slot `d` = `addr[15:11]` below 16 sets only `xlat_addr[16+d]` in the upper half. Slots 16 to 31 set no upper bit.
- R6: On conversion, if `hide_mask[d]` is 1 for a slot below 16, its normal line stays low and only `xlat_addr[31]` is set.
- R7: An upstream hierarchical phase with `sec_bus` < bus <= `sub_bus` yields action 3 (forward), with `xlat_addr` equal to `addr`.
- R8: An upstream hierarchical phase whose bus is below `sec_bus` or above `sub_bus` yields action 0.
- R9: An upstream hierarchical configuration write with bus equal to `sec_bus`, slot 31, function 7 (`addr[10:8]`) and register 0 (`addr[7:2]`) yields action 4 (special cycle) with `xlat_addr` 0. A read with that pattern is converted as in R4.
- R10: On the downstream side (`from_down`=1), only a hierarchical configuration write with bus equal to `pri_bus` and the R9 pattern yields action 4. Every other downstream phase, including reads and local-format phases with `idsel`, yields action 0.
- R11: A claimed configuration write loads `own_dev` with `addr[15:11]`, visible with the action. Claimed reads leave `own_dev` unchanged.
- R12: `act_valid` is `addr_valid` delayed by one clock. While `act_valid` is 0, `act` is 0 and `xlat_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | An address phase is presented this cycle |
| from_down | input | 1 | 1: phase seen on downstream side; 0: upstream side |
| addr | input | 32 | Address-phase address |
| cmd | input | 4 | Bus command |
| idsel | input | 1 | Device select for the bridge itself |
| pri_bus | input | 8 | Bus number on the upstream side |
| sec_bus | input | 8 | Bus number directly below |
| sub_bus | input | 8 | Highest bus number below |
| hide_mask | input | 16 | Per-slot hide enable |
| act_valid | output | 1 | Registered result valid |
| act | output | 3 | Action: 0 none, 1 claim, 2 to local, 3 forward, 4 special |
| xlat_addr | output | 32 | Address to drive on the target side |
| own_dev | output | 5 | Slot number last written to the bridge |

## Verification
A wrong bus-range comparison shows as a wrong action code on the very next cycle. So does a bad pattern match, which would route a phase as forward or convert instead of special or none. A fault in the slot decoder or in the hide-mask steering shows one cycle later as a wrong or doubled bit in `xlat_addr[31:16]`. A stored slot number that fails to update, or updates on a read, stays visible on `own_dev` until the next claimed write. That is why each write is followed by a read that reads it back.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int ADDR_W    = 32;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int SEL_BASE  = 16;
    localparam int SEL_LINES = 16;
    localparam int HIDE_BIT  = 31;
    localparam int SEL_IDX_W = $clog2(SEL_LINES);

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_CLAIM   = 3'd1,
        ACT_TO_LOC  = 3'd2,
        ACT_FORWARD = 3'd3,
        ACT_SPECIAL = 3'd4
    } cfg_act_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [2:0]       fn;
        logic [5:0]       regno;
        logic [1:0]       fmt;
    } cfg_fields_t;

    function automatic cfg_fields_t split_addr(input logic [ADDR_W-1:0] a);
        cfg_fields_t f;
        f.bus   = a[23:16];
        f.dev   = a[15:11];
        f.fn    = a[10:8];
        f.regno = a[7:2];
        f.fmt   = a[1:0];
        return f;
    endfunction

    function automatic logic is_special_pattern(input cfg_fields_t f, input logic wr);
        return wr && (f.dev == 5'h1f) && (f.fn == 3'h7) && (f.regno == 6'h00);
    endfunction

endpackage

// File: rtl/cfg_classify.sv
module cfg_classify
    import cfg_route_pkg::*;
(
    input  logic              valid,
    input  logic              from_down,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic              idsel,
    input  logic [BUS_W-1:0]  pri_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output cfg_act_e          act
);
    cfg_fields_t f;
    logic        is_cfg;
    logic        is_wr;
    logic        pat;

    always_comb begin
        f      = split_addr(addr);
        is_cfg = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        is_wr  = (cmd == CMD_CFG_WR);
        pat    = is_special_pattern(f, is_wr);
        act    = ACT_NONE;
        if (valid && is_cfg) begin
            if (!from_down) begin
                if (f.fmt == 2'b00) begin
                    if (idsel) act = ACT_CLAIM;
                end else if (f.fmt == 2'b01) begin
                    if (f.bus == sec_bus)
                        act = pat ? ACT_SPECIAL : ACT_TO_LOC;
                    else if ((f.bus > sec_bus) && (f.bus <= sub_bus))
                        act = ACT_FORWARD;
                end
            end else begin
                if ((f.fmt == 2'b01) && (f.bus == pri_bus) && pat)
                    act = ACT_SPECIAL;
            end
        end
    end
endmodule

// File: rtl/cfg_sel_gen.sv
module cfg_sel_gen
    import cfg_route_pkg::*;
#(
    parameter int LINES = SEL_LINES,
    parameter int HIDE  = HIDE_BIT - SEL_BASE
)(
    input  logic [DEV_W-1:0] dev,
    input  logic [LINES-1:0] hide_mask,
    output logic [LINES-1:0] sel
);
    localparam int IDX_W = $clog2(LINES);

    logic [LINES-1:0] plain;
    logic             in_range;
    logic             hidden;

    assign in_range = (dev < DEV_W'(LINES));
    assign hidden   = in_range && hide_mask[dev[IDX_W-1:0]];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign plain[i] = (dev == DEV_W'(i)) && !hide_mask[i];
    end

    always_comb begin
        sel       = plain;
        sel[HIDE] = plain[HIDE] | hidden;
    end
endmodule

// File: rtl/cfg_route.sv
module cfg_route
    import cfg_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 addr_valid,
    input  logic                 from_down,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [3:0]           cmd,
    input  logic                 idsel,
    input  logic [BUS_W-1:0]     pri_bus,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic [BUS_W-1:0]     sub_bus,
    input  logic [SEL_LINES-1:0] hide_mask,
    output logic                 act_valid,
    output logic [2:0]           act,
    output logic [ADDR_W-1:0]    xlat_addr,
    output logic [DEV_W-1:0]     own_dev
);
    cfg_act_e             act_d;
    logic [SEL_LINES-1:0] sel;
    logic [ADDR_W-1:0]    xlat_d;
    logic [ADDR_W-1:0]    loc_addr;

    cfg_classify u_classify (
        .valid     (addr_valid),
        .from_down (from_down),
        .addr      (addr),
        .cmd       (cmd),
        .idsel     (idsel),
        .pri_bus   (pri_bus),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus),
        .act       (act_d)
    );

    cfg_sel_gen u_sel (
        .dev       (addr[15:11]),
        .hide_mask (hide_mask),
        .sel       (sel)
    );

    assign loc_addr = {sel, 5'b0, addr[10:2], 2'b00};

    always_comb begin
        case (act_d)
            ACT_CLAIM:   xlat_d = addr;
            ACT_FORWARD: xlat_d = addr;
            ACT_TO_LOC:  xlat_d = loc_addr;
            default:     xlat_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_valid <= 1'b0;
            act       <= ACT_NONE;
            xlat_addr <= '0;
            own_dev   <= '0;
        end else begin
            act_valid <= addr_valid;
            act       <= act_d;
            xlat_addr <= xlat_d;
            if (act_d == ACT_CLAIM && cmd == CMD_CFG_WR)
                own_dev <= addr[15:11];
        end
    end
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk
    import cfg_route_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 addr_valid,
    input logic [ADDR_W-1:0]    addr,
    input logic [3:0]           cmd,
    input logic [SEL_LINES-1:0] hide_mask,
    input logic                 act_valid,
    input logic [2:0]           act,
    input logic [ADDR_W-1:0]    xlat_addr,
    input logic [DEV_W-1:0]     own_dev
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> act_valid); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !act_valid |-> (act == ACT_NONE && xlat_addr == '0)); // R12

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        act == ACT_NONE |-> xlat_addr == '0); // R3

    AST_LOC_FORMAT: assert property (@(posedge clk) disable iff (rst)
        act == ACT_TO_LOC |-> (xlat_addr[15:11] == '0 && xlat_addr[1:0] == 2'b00)); // R4

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        act == ACT_TO_LOC |-> $countones(xlat_addr[31:16]) <= 1); // R5

    AST_HIDE_LINE: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_TO_LOC && $past(addr[15]) == 1'b0 && $past(hide_mask[addr[14:11]]))
        |-> xlat_addr[31:16] == 16'h8000); // R6

    AST_FWD_SAME: assert property (@(posedge clk) disable iff (rst)
        act == ACT_FORWARD |-> xlat_addr == $past(addr)); // R7

    AST_OWN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_CLAIM && $past(cmd) == CMD_CFG_WR) |-> own_dev == $past(addr[15:11])); // R11
endmodule

bind cfg_route cfg_route_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .addr       (addr),
    .cmd        (cmd),
    .hide_mask  (hide_mask),
    .act_valid  (act_valid),
    .act        (act),
    .xlat_addr  (xlat_addr),
    .own_dev    (own_dev)
);

// File: tb/cfg_route_tb.sv
module cfg_route_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic        from_down = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  cmd = '0;
    logic        idsel = 1'b0;
    logic [7:0]  pri_bus = 8'd2;
    logic [7:0]  sec_bus = 8'd5;
    logic [7:0]  sub_bus = 8'd9;
    logic [15:0] hide_mask = '0;
    logic        act_valid;
    logic [2:0]  act;
    logic [31:0] xlat_addr;
    logic [4:0]  own_dev;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [3:0] RD = 4'b1010;
    localparam logic [3:0] WR = 4'b1011;

    always #5 clk = ~clk;

    cfg_route u_dut (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .from_down(from_down),
        .addr(addr), .cmd(cmd), .idsel(idsel), .pri_bus(pri_bus),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .hide_mask(hide_mask),
        .act_valid(act_valid), .act(act), .xlat_addr(xlat_addr), .own_dev(own_dev)
    );

    function automatic logic [31:0] hier(input logic [7:0] bus, input logic [4:0] dev,
                                         input logic [2:0] fn, input logic [5:0] rg);
        return {8'h00, bus, dev, fn, rg, 2'b01};
    endfunction

    function automatic logic [31:0] loc(input logic [15:0] upper, input logic [2:0] fn,
                                        input logic [5:0] rg);
        return {upper, 5'b0, fn, rg, 2'b00};
    endfunction

    task automatic check(input string req, input logic [2:0] exp_act,
                         input logic [31:0] exp_addr);
        checks++;
        if (act_valid !== 1'b1 || act !== exp_act || xlat_addr !== exp_addr) begin
            errors++;
            $display("FAIL %s: valid=%0b act=%0d addr=%h expected valid=1 act=%0d addr=%h",
                     req, act_valid, act, xlat_addr, exp_act, exp_addr);
        end
    endtask

    task automatic check_dev(input string req, input logic [4:0] exp);
        checks++;
        if (own_dev !== exp) begin
            errors++;
            $display("FAIL %s: own_dev=%0d expected %0d", req, own_dev, exp);
        end
    endtask

    task automatic phase(input logic side, input logic [3:0] c, input logic [31:0] a,
                         input logic sel);
        @(negedge clk);
        addr_valid = 1'b1; from_down = side; cmd = c; addr = a; idsel = sel;
        @(negedge clk);
        addr_valid = 1'b0; idsel = 1'b0; cmd = 4'b0000; addr = '0; from_down = 1'b0;
    endtask

    task automatic t_reset;
        checks++;
        if (act_valid !== 1'b0 || act !== 3'd0 || xlat_addr !== '0 || own_dev !== '0) begin
            errors++;
            $display("FAIL R1: valid=%0b act=%0d addr=%h dev=%0d expected 0 0 0 0",
                     act_valid, act, xlat_addr, own_dev);
        end
    endtask

    task automatic t_claim;
        logic [31:0] a;
        a = {16'h0000, 5'd7, 3'd1, 6'd4, 2'b00};
        phase(1'b0, WR, a, 1'b1);
        check("R2 claim write", 3'd1, a);
        check_dev("R11 write loads", 5'd7);
        a = {16'h0000, 5'd12, 3'd0, 6'd1, 2'b00};
        phase(1'b0, RD, a, 1'b1);
        check("R2 claim read", 3'd1, a);
        check_dev("R11 read keeps", 5'd7);
    endtask

    task automatic t_reject;
        phase(1'b0, RD, {16'h0, 5'd7, 3'd0, 6'd0, 2'b00}, 1'b0);
        check("R3 no idsel", 3'd0, 32'h0);
        phase(1'b0, 4'b0110, {16'h0, 5'd7, 3'd0, 6'd0, 2'b00}, 1'b1);
        check("R3 non-config cmd", 3'd0, 32'h0);
        phase(1'b0, WR, {16'h0, 5'd9, 3'd0, 6'd0, 2'b10}, 1'b1);
        check("R3 format 10", 3'd0, 32'h0);
        check_dev("R3 ignored write keeps own_dev", 5'd7);
    endtask

    task automatic t_convert;
        phase(1'b0, RD, hier(8'd5, 5'd3, 3'd2, 6'd5), 1'b0);
        check("R4 R5 slot 3", 3'd2, loc(16'h0008, 3'd2, 6'd5));
        phase(1'b0, WR, hier(8'd5, 5'd0, 3'd0, 6'd0), 1'b0);
        check("R5 slot 0", 3'd2, loc(16'h0001, 3'd0, 6'd0));
        phase(1'b0, RD, hier(8'd5, 5'd20, 3'd7, 6'd63), 1'b0);
        check("R5 slot 20 none", 3'd2, loc(16'h0000, 3'd7, 6'd63));
    endtask

    task automatic t_hide;
        hide_mask = 16'h0020;
        phase(1'b0, RD, hier(8'd5, 5'd5, 3'd1, 6'd2), 1'b0);
        check("R6 hidden slot 5", 3'd2, loc(16'h8000, 3'd1, 6'd2));
        phase(1'b0, RD, hier(8'd5, 5'd6, 3'd1, 6'd2), 1'b0);
        check("R6 unhidden slot 6", 3'd2, loc(16'h0040, 3'd1, 6'd2));
        hide_mask = 16'h0000;
    endtask

    task automatic t_forward;
        phase(1'b0, WR, hier(8'd9, 5'd4, 3'd0, 6'd8), 1'b0);
        check("R7 bus at sub", 3'd3, hier(8'd9, 5'd4, 3'd0, 6'd8));
        phase(1'b0, RD, hier(8'd6, 5'd31, 3'd7, 6'd0), 1'b0);
        check("R7 bus just above sec", 3'd3, hier(8'd6, 5'd31, 3'd7, 6'd0));
        phase(1'b0, RD, hier(8'd10, 5'd4, 3'd0, 6'd8), 1'b0);
        check("R8 bus above sub", 3'd0, 32'h0);
        phase(1'b0, RD, hier(8'd4, 5'd4, 3'd0, 6'd8), 1'b0);
        check("R8 bus below sec", 3'd0, 32'h0);
    endtask

    task automatic t_special;
        phase(1'b0, WR, hier(8'd5, 5'd31, 3'd7, 6'd0), 1'b0);
        check("R9 downward special", 3'd4, 32'h0);
        phase(1'b0, RD, hier(8'd5, 5'd31, 3'd7, 6'd0), 1'b0);
        check("R9 read pattern converts", 3'd2, loc(16'h0000, 3'd7, 6'd0));
        phase(1'b1, WR, hier(8'd2, 5'd31, 3'd7, 6'd0), 1'b0);
        check("R10 upward special", 3'd4, 32'h0);
        phase(1'b1, RD, hier(8'd2, 5'd31, 3'd7, 6'd0), 1'b0);
        check("R10 upward read ignored", 3'd0, 32'h0);
        phase(1'b1, WR, {16'h0, 5'd3, 3'd0, 6'd0, 2'b00}, 1'b1);
        check("R10 upward local ignored", 3'd0, 32'h0);
        check_dev("R10 own_dev kept", 5'd7);
    endtask

    task automatic t_idle;
        @(negedge clk);
        addr = hier(8'd9, 5'd1, 3'd0, 6'd0); cmd = RD;
        @(negedge clk);
        checks++;
        if (act_valid !== 1'b0 || act !== 3'd0 || xlat_addr !== '0) begin
            errors++;
            $display("FAIL R12: valid=%0b act=%0d addr=%h expected 0 0 0",
                     act_valid, act, xlat_addr);
        end
        addr = '0; cmd = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_claim();
        t_reject();
        t_convert();
        t_hide();
        t_forward();
        t_special();
        t_idle();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule